// File: doc/BRIEF.md
# Interlaced field parity detector

This block tells odd fields from even fields in interlaced video. It watches the sliced composite sync and a one-cycle strobe that marks the start of the vertical pulse. From these it works out whether vertical began on a whole-line boundary or halfway through a line, measured from the last horizontal sync. A whole-line start means an odd field and a half-line start means an even field. The result is a single flag that can change only when a vertical start arrives.

Equalizing and serration pulses come at twice the line rate. They are kept off the line grid by a spacing rule that scales with the programmed line length. When two fields in a row show the same phase, the scan is taken as progressive and the flag keeps its value. Vertical detection and slicing happen upstream. The line length is an input, so one instance covers any scan rate.

Top module: `field_parity_det`

## Requirements
- R1: While rst_ni is low, odd_o is 0.
- R2: odd_o changes only on the clock edge that samples vstart_i high; sync activity without a strobe leaves it unchanged.
- R3: A rising edge of sync_i (1 in cycle k-1 → 0, 1 in cycle k) becomes a line start only if at least line_len_i - floor(line_len_i/4) clocks have passed since the previous line start, or if no line start has occurred since reset. Closer edges are ignored.
- R4: The field phase is the number of clocks n from the edge that accepted the last line start to the edge that samples vstart_i.
- R5: A phase n with floor(L/4) <= n < L - floor(L/4), where L = line_len_i, is classed half-line. Any other phase is classed whole-line.
- R6: On a strobe whose class differs from the previous strobe's class, odd_o becomes 1 for whole-line and 0 for half-line.
- R7: On a strobe whose class equals the previous strobe's class (progressive scan), odd_o keeps its value.
- R8: The first strobe after reset only records its class and leaves odd_o at 0.
- R9: Both thresholds follow line_len_i as it is at run time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Sliced composite sync, 1 during sync tip |
| vstart_i | input | 1 | One-cycle strobe at vertical pulse start |
| line_len_i | input | CW | Line period in clocks |
| odd_o | output | 1 | 1 in odd field, 0 in even field |

## Verification
The bench places the strobe right at the quarter and three-quarter phase limits, on both sides of each. A design with an off-by-one compare would flip the flag on one of these rows. It puts a stray pulse at exactly 48 and at 47 clocks after a line start with a 64-clock line. A design that rejected or accepted the wrong one would measure the phase from the wrong edge and report the wrong field. It also changes the line length at run time, checks that the first field after reset leaves the flag at 0, and runs sync with no strobe. A design with fixed thresholds, or one that updated without a strobe or a reference field, would miss these checks.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  typedef enum logic {
    PH_WHOLE = 1'b0,
    PH_HALF  = 1'b1
  } phase_e;
endpackage

// File: rtl/fpd_edge_filter.sv
module fpd_edge_filter #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic [CW-1:0] line_len_i,
  output logic [CW-1:0] phase_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic          sync_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;
  logic          rise, accept;

  assign thr    = line_len_i - (line_len_i >> 2);
  assign rise   = sync_i & ~sync_q;
  assign accept = rise & (cnt_q >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      cnt_q  <= CMAX;   // saturated: first edge after reset is accepted
    end else begin
      sync_q <= sync_i;
      if (accept)            cnt_q <= {{(CW-1){1'b0}}, 1'b1};
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = cnt_q;

  // Two accepted line starts can never sit on adjacent cycles.
  assert_edge_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && line_len_i >= 4) |=> !accept);
endmodule

// File: rtl/fpd_classifier.sv
module fpd_classifier
  import fpd_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CW-1:0] phase_i,
  input  logic [CW-1:0] line_len_i,
  output phase_e        cls_o
);
  logic [CW-1:0] lo, hi;

  assign lo = line_len_i >> 2;
  assign hi = line_len_i - lo;

  always_comb begin
    if (phase_i >= lo && phase_i < hi) cls_o = PH_HALF;
    else                               cls_o = PH_WHOLE;
  end
endmodule

// File: rtl/fpd_tracker.sv
module fpd_tracker
  import fpd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   vstart_i,
  input  phase_e cls_i,
  output logic   odd_o
);
  logic   have_prev_q;
  phase_e prev_q;
  logic   odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      prev_q      <= PH_WHOLE;
      odd_q       <= 1'b0;
    end else if (vstart_i) begin
      have_prev_q <= 1'b1;
      prev_q      <= cls_i;
      if (have_prev_q && cls_i != prev_q) odd_q <= (cls_i == PH_WHOLE);
    end
  end

  assign odd_o = odd_q;

  assert_hold_no_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vstart_i |=> $stable(odd_o));

  assert_first_field_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vstart_i && !have_prev_q) |=> $stable(odd_o));

  assert_progressive_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vstart_i && have_prev_q && cls_i == prev_q) |=> $stable(odd_o));

  assert_parity_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vstart_i && have_prev_q && cls_i != prev_q) |=> (odd_o == ($past(cls_i) == PH_WHOLE)));
endmodule

// File: rtl/field_parity_det.sv
module field_parity_det
  import fpd_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          vstart_i,
  input  logic [CW-1:0] line_len_i,
  output logic          odd_o
);
  logic [CW-1:0] phase;
  phase_e        cls;

  fpd_edge_filter #(.CW(CW)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .line_len_i (line_len_i),
    .phase_o    (phase)
  );

  fpd_classifier #(.CW(CW)) u_cls (
    .phase_i    (phase),
    .line_len_i (line_len_i),
    .cls_o      (cls)
  );

  fpd_tracker u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vstart_i (vstart_i),
    .cls_i    (cls),
    .odd_o    (odd_o)
  );

  assert_reset_low_R1: assert property (@(posedge clk_i) !rst_ni |-> !odd_o);
endmodule

// File: tb/field_parity_det_tb.sv
module field_parity_det_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  typedef struct packed {
    logic [7:0] eq_at;  // stray pulse offset from line start, 0 = none
    logic [7:0] off;    // strobe offset from line start
    logic       exp;
  } row_t;

  // line length 64: half window is [16,48), spacing threshold 48
  localparam row_t ROWS [13] = '{
    '{8'd0,  8'd3,  1'b0},  // R8 first field: whole, flag stays 0
    '{8'd32, 8'd34, 1'b0},  // R3 eq pulse ignored, R5 half -> R6 0
    '{8'd0,  8'd60, 1'b1},  // R5 whole
    '{8'd0,  8'd16, 1'b0},  // R5 lower limit half
    '{8'd0,  8'd15, 1'b1},  // R5 just below lower limit
    '{8'd0,  8'd47, 1'b0},  // R5 just below upper limit
    '{8'd0,  8'd48, 1'b1},  // R5 upper limit whole
    '{8'd48, 8'd68, 1'b0},  // R3 edge at threshold accepted, R4 phase 20
    '{8'd47, 8'd67, 1'b1},  // R3 edge below threshold ignored, phase 67
    '{8'd0,  8'd20, 1'b0},  // R6 half
    '{8'd0,  8'd25, 1'b0},  // R7 repeated half holds
    '{8'd0,  8'd60, 1'b1},  // R6 whole
    '{8'd0,  8'd61, 1'b1}   // R7 repeated whole holds
  };

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          sync_i;
  logic          vstart_i;
  logic [CW-1:0] line_len_i;
  logic          odd_o;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_parity_det #(.CW(CW)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .vstart_i   (vstart_i),
    .line_len_i (line_len_i),
    .odd_o      (odd_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input logic exp, input string tag);
    checks++;
    if (odd_o !== exp) begin
      errors++;
      $display("FAIL %s: odd_o=%0b expected %0b", tag, odd_o, exp);
    end
  endtask

  task automatic preamble(input int len);
    repeat (3) begin
      sync_i = 1'b1; step(); sync_i = 1'b0;
      repeat (len-1) step();
    end
  endtask

  task automatic field(input int len, input int eq_at, input int off, input bit strobe);
    preamble(len);
    sync_i = 1'b1; step(); sync_i = 1'b0;
    if (eq_at > 0) begin
      repeat (eq_at-1) step();
      sync_i = 1'b1; step(); sync_i = 1'b0;
      repeat (off-eq_at-1) step();
    end else begin
      repeat (off-1) step();
    end
    if (strobe) begin
      vstart_i = 1'b1; step(); vstart_i = 1'b0;
    end else begin
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; sync_i = 1'b0; vstart_i = 1'b0; line_len_i = 64;
    repeat (3) step();
    check(1'b0, "R1 reset value");
    rst_ni = 1'b1;
    step();

    for (int i = 0; i < 13; i++) begin
      field(64, int'(ROWS[i].eq_at), int'(ROWS[i].off), 1'b1);
      check(ROWS[i].exp, $sformatf("table row %0d (R3 R4 R5 R6 R7 R8)", i));
    end

    // R2: half-line phase with no strobe must not touch the flag (currently 1)
    field(64, 32, 34, 1'b0);
    repeat (5) step();
    check(1'b1, "R2 no strobe, no change");

    // R9: line length 100, half window [25,75)
    line_len_i = 100;
    field(100, 0, 74, 1'b1);
    check(1'b0, "R9 phase 74 of 100 is half");
    field(100, 0, 75, 1'b1);
    check(1'b1, "R9 phase 75 of 100 is whole");
    field(100, 60, 90, 1'b1);
    check(1'b1, "R9 R3 edge at 60 of 100 ignored");

    // R1 mid-run reset, then R8 first field after it
    rst_ni = 1'b0;
    step();
    check(1'b0, "R1 reset mid-run");
    rst_ni = 1'b1;
    line_len_i = 64;
    step();
    field(64, 0, 20, 1'b1);
    check(1'b0, "R8 first field after reset");
    field(64, 0, 3, 1'b1);
    check(1'b1, "R6 whole after half");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule